// File: doc/BRIEF.md
# Write-Protect and Page Command Decoder

This block sits behind the bit-level receiver of a serial-presence-detect memory slave. Each received byte comes in on a valid/ready stream with its position in the transfer (0 is the select byte that follows a START or repeated START, 1 is the byte after it, 2 and above are the bytes after that). The block classifies the select byte as either an access to the memory array or one of the special commands. The special commands set protection on one 128-byte block, clear protection on all blocks, report one block's protection, pick the active 256-byte page, or report that page. For every accepted byte it returns a one-cycle ACK/NoACK decision that the bit-level logic drives in the ninth clock slot.

The block holds four protection flags and the page-select bit in registers. A protection change waits for the STOP that follows the data byte. At that STOP it commits and pulses a request to the write-cycle timer. While that timer reports busy, every select byte is refused, so a bus master can poll until the cycle ends. Status queries report through ACK versus NoACK, never through data.

The byte stream is `rx_valid`/`rx_ready`. The block never stalls a byte, except in the cycle where `stop_det` is high. In that cycle `rx_ready` is low and a byte offered with it is dropped, so the byte gets no decision.

Top module: `spd_cmd_decoder`

## Requirements
- R1: A select byte whose upper nibble is 1010 and whose bits 3..1 equal `strap[2:0]` is ACKed and opens a memory access (bit 0 set means read). Any other value in bits 3..1 under that nibble gets NoACK.
- R2: With upper nibble 0110, bit 0 = 0 and `strap0_hv` high, the codes in bits 3..1 of 001, 100, 101 and 000 set protection on blocks 0, 1, 2 and 3. The select, address and data bytes are ACKed. The flag is set at the STOP after the data byte, and `wc_start` pulses for one cycle after that STOP.
- R3: A set-protect or clear-all select byte with `strap0_hv` low gets NoACK and changes no flag.
- R4: A set-protect aimed at a block that is already protected gets NoACK on all its bytes and raises no `wc_start`.
- R5: Code 011 with bit 0 = 0 and `strap0_hv` high clears all four flags at the STOP after the data byte and pulses `wc_start`.
- R6: A STOP that arrives before any data byte of a set or clear command commits nothing and raises no `wc_start`.
- R7: With bit 0 = 1, the block codes of R2 report that block's protection: ACK when unprotected, NoACK when protected, at any strap level. The bytes after it get NoACK.
- R8: Code 110 with bit 0 = 0 selects page 0, and code 111 with bit 0 = 0 selects page 1; both are ACKed. Code 110 with bit 0 = 1 gives ACK when page 0 is active and NoACK when page 1 is active.
- R9: After reset, `page_sel` is 0, all flags are 0, and no `ack_valid` or `wc_start` is raised.
- R10: Select-byte encodings not listed in R1 to R8 get NoACK, and the bytes after them get NoACK.
- R11: While `wr_busy` is high, every select byte gets NoACK.
- R12: In a memory write, the byte after the select is ACKed and its bit 7 is kept. The data bytes are ACKed only if block {`page_sel`, kept bit 7} is unprotected. In a memory read, the bytes after the select are not ACKed by this block.
- R13: `ack_valid` rises exactly one cycle after an accepted byte. When `stop_det` is high, `rx_ready` is low and the offered byte gets no `ack_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte is offered |
| rx_ready | output | 1 | Byte accepted this cycle (low during STOP) |
| rx_data | input | 8 | Received byte |
| rx_index | input | 2 | Byte position: 0 select, 1 address, 2+ data (saturating) |
| stop_det | input | 1 | One-cycle STOP condition strobe |
| wr_busy | input | 1 | Write-cycle timer is running |
| strap | input | 3 | Address straps, strap[0] is the lowest |
| strap0_hv | input | 1 | Strap 0 is at the high-voltage level |
| ack | output | 1 | ACK (1) or NoACK (0) for the last accepted byte |
| ack_valid | output | 1 | `ack` is valid this cycle |
| wc_start | output | 1 | One-cycle request to start the write cycle |
| mem_active | output | 1 | A memory-array access is open |
| mem_read | output | 1 | The open memory access is a read |
| prot_flags | output | 4 | Protection flag per block |
| page_sel | output | 1 | Active 256-byte page |

## Verification
The hardest state to reach is one where a protection flag is already set and a second command depends on it. Examples are a repeated set-protect that must be refused on every byte, or a memory data byte whose block is found through the page bit. Directed tasks first commit a protection change with a full select/address/data/STOP sequence. They then flip the page through its own command and replay accesses against the same block from both pages. Early-STOP and busy-polling tasks run between these so that a commit that should not happen would show up in the flags seen later.

// File: rtl/spd_cmd_pkg.sv
package spd_cmd_pkg;

  localparam int unsigned NBLK   = 4;
  localparam int unsigned BLK_W  = $clog2(NBLK);
  localparam logic [3:0]  MEM_ID  = 4'b1010;
  localparam logic [3:0]  PROT_ID = 4'b0110;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_MEM,
    CMD_SETP,
    CMD_CLR,
    CMD_RDST,
    CMD_PG0,
    CMD_PG1,
    CMD_RDPG
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEM_WR,
    ST_MEM_RD,
    ST_ARM_SET,
    ST_ARM_CLR,
    ST_NACK
  } state_e;

  typedef struct packed {
    logic             ok;
    logic [BLK_W-1:0] blk;
  } blk_map_t;

  // non-binary block code mapping in bits 3..1 of the select byte
  function automatic blk_map_t map_blk(input logic [2:0] code);
    blk_map_t m;
    m.ok  = 1'b1;
    m.blk = '0;
    case (code)
      3'b001:  m.blk = BLK_W'(0);
      3'b100:  m.blk = BLK_W'(1);
      3'b101:  m.blk = BLK_W'(2);
      3'b000:  m.blk = BLK_W'(3);
      default: m.ok  = 1'b0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/spd_sel_decode.sv
module spd_sel_decode
  import spd_cmd_pkg::*;
(
  input  logic [7:0]       sel_byte,
  input  logic [2:0]       strap,
  input  logic             strap0_hv,
  output cmd_e             cmd,
  output logic [BLK_W-1:0] blk
);

  blk_map_t m;
  logic     rd;

  assign m  = map_blk(sel_byte[3:1]);
  assign rd = sel_byte[0];
  assign blk = m.blk;

  always_comb begin
    cmd = CMD_NONE;
    if (sel_byte[7:4] == MEM_ID) begin
      if (sel_byte[3:1] == strap) cmd = CMD_MEM;
    end else if (sel_byte[7:4] == PROT_ID) begin
      if (m.ok) begin
        if (rd)             cmd = CMD_RDST;
        else if (strap0_hv) cmd = CMD_SETP;
      end else begin
        case ({sel_byte[3:1], rd})
          4'b0110: if (strap0_hv) cmd = CMD_CLR;
          4'b1100: cmd = CMD_PG0;
          4'b1110: cmd = CMD_PG1;
          4'b1101: cmd = CMD_RDPG;
          default: cmd = CMD_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/spd_prot_regs.sv
module spd_prot_regs
  import spd_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_blk,
  input  logic             clr_en,
  input  logic             pg_wr,
  input  logic             pg_val,
  output logic [NBLK-1:0]  flags,
  output logic             page
);

  for (genvar i = 0; i < NBLK; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                flags[i] <= 1'b0;
      else if (clr_en)                           flags[i] <= 1'b0;
      else if (set_en && set_blk == BLK_W'(i))   flags[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     page <= 1'b0;
    else if (pg_wr) page <= pg_val;
  end

endmodule

// File: rtl/spd_ack_ctrl.sv
module spd_ack_ctrl
  import spd_cmd_pkg::*;
#(
  parameter int unsigned IDX_W = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [IDX_W-1:0] rx_index,
  input  logic             addr_msb,
  input  logic             sel_rd,
  input  cmd_e             cmd,
  input  logic [BLK_W-1:0] blk,
  input  logic             stop_det,
  input  logic             wr_busy,
  input  logic [NBLK-1:0]  flags,
  input  logic             page,
  output logic             ack,
  output logic             ack_valid,
  output logic             wc_start,
  output logic             set_en,
  output logic             clr_en,
  output logic [BLK_W-1:0] set_blk,
  output logic             pg_wr,
  output logic             pg_val,
  output logic             mem_active,
  output logic             mem_read
);

  state_e           st_q, st_d;
  logic [BLK_W-1:0] pblk_q, pblk_d;
  logic             armed_q, armed_d;
  logic             a7_q, a7_d;
  logic             ack_d;

  always_comb begin
    st_d    = st_q;
    pblk_d  = pblk_q;
    armed_d = armed_q;
    a7_d    = a7_q;
    ack_d   = 1'b0;
    set_en  = 1'b0;
    clr_en  = 1'b0;
    pg_wr   = 1'b0;
    pg_val  = 1'b0;
    if (stop_det) begin
      st_d    = ST_IDLE;
      armed_d = 1'b0;
      if (armed_q) begin
        set_en = (st_q == ST_ARM_SET);
        clr_en = (st_q == ST_ARM_CLR);
      end
    end else if (fire) begin
      if (rx_index == '0) begin
        armed_d = 1'b0;
        st_d    = ST_IDLE;
        if (!wr_busy) begin
          case (cmd)
            CMD_MEM: begin
              ack_d = 1'b1;
              st_d  = sel_rd ? ST_MEM_RD : ST_MEM_WR;
            end
            CMD_SETP: begin
              pblk_d = blk;
              ack_d  = !flags[blk];
              st_d   = flags[blk] ? ST_NACK : ST_ARM_SET;
            end
            CMD_CLR: begin
              ack_d = 1'b1;
              st_d  = ST_ARM_CLR;
            end
            CMD_RDST: begin
              ack_d = !flags[blk];
              st_d  = ST_NACK;
            end
            CMD_PG0, CMD_PG1: begin
              ack_d  = 1'b1;
              pg_wr  = 1'b1;
              pg_val = (cmd == CMD_PG1);
              st_d   = ST_NACK;
            end
            CMD_RDPG: begin
              ack_d = !page;
              st_d  = ST_NACK;
            end
            default: st_d = ST_IDLE;
          endcase
        end
      end else if (rx_index == IDX_W'(1)) begin
        case (st_q)
          ST_MEM_WR: begin
            ack_d = 1'b1;
            a7_d  = addr_msb;
          end
          ST_ARM_SET, ST_ARM_CLR: ack_d = 1'b1;
          default: ack_d = 1'b0;
        endcase
      end else begin
        case (st_q)
          ST_MEM_WR: ack_d = !flags[{page, a7_q}];
          ST_ARM_SET, ST_ARM_CLR: begin
            ack_d   = 1'b1;
            armed_d = 1'b1;
          end
          default: ack_d = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      pblk_q    <= '0;
      armed_q   <= 1'b0;
      a7_q      <= 1'b0;
      ack       <= 1'b0;
      ack_valid <= 1'b0;
      wc_start  <= 1'b0;
    end else begin
      st_q      <= st_d;
      pblk_q    <= pblk_d;
      armed_q   <= armed_d;
      a7_q      <= a7_d;
      ack       <= ack_d;
      ack_valid <= fire && !stop_det;
      wc_start  <= set_en || clr_en;
    end
  end

  assign set_blk    = pblk_q;
  assign mem_active = (st_q == ST_MEM_WR) || (st_q == ST_MEM_RD);
  assign mem_read   = (st_q == ST_MEM_RD);

endmodule

// File: rtl/spd_cmd_decoder.sv
module spd_cmd_decoder
  import spd_cmd_pkg::*;
#(
  parameter int unsigned IDX_W = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  input  logic [IDX_W-1:0] rx_index,
  input  logic             stop_det,
  input  logic             wr_busy,
  input  logic [2:0]       strap,
  input  logic             strap0_hv,
  output logic             ack,
  output logic             ack_valid,
  output logic             wc_start,
  output logic             mem_active,
  output logic             mem_read,
  output logic [NBLK-1:0]  prot_flags,
  output logic             page_sel
);

  cmd_e             cmd;
  logic [BLK_W-1:0] blk;
  logic             set_en, clr_en, pg_wr, pg_val;
  logic [BLK_W-1:0] set_blk;
  logic             fire;

  assign rx_ready = !stop_det;
  assign fire     = rx_valid && rx_ready;

  spd_sel_decode u_dec (
    .sel_byte  (rx_data),
    .strap     (strap),
    .strap0_hv (strap0_hv),
    .cmd       (cmd),
    .blk       (blk)
  );

  spd_ack_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .rx_index   (rx_index),
    .addr_msb   (rx_data[7]),
    .sel_rd     (rx_data[0]),
    .cmd        (cmd),
    .blk        (blk),
    .stop_det   (stop_det),
    .wr_busy    (wr_busy),
    .flags      (prot_flags),
    .page       (page_sel),
    .ack        (ack),
    .ack_valid  (ack_valid),
    .wc_start   (wc_start),
    .set_en     (set_en),
    .clr_en     (clr_en),
    .set_blk    (set_blk),
    .pg_wr      (pg_wr),
    .pg_val     (pg_val),
    .mem_active (mem_active),
    .mem_read   (mem_read)
  );

  spd_prot_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (set_en),
    .set_blk (set_blk),
    .clr_en  (clr_en),
    .pg_wr   (pg_wr),
    .pg_val  (pg_val),
    .flags   (prot_flags),
    .page    (page_sel)
  );

endmodule

// File: rtl/spd_cmd_decoder_chk.sv
module spd_cmd_decoder_chk #(
  parameter int unsigned IDX_W = 2
)(
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [IDX_W-1:0] rx_index,
  input logic             stop_det,
  input logic             wr_busy,
  input logic             ack,
  input logic             ack_valid,
  input logic             wc_start,
  input logic [3:0]       prot_flags,
  input logic             page_sel
);

  p_page_reset_r9: assert property (@(posedge clk) !rst_n |=> !page_sel && prot_flags == 4'b0);

  p_ack_timing_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> ack_valid);

  p_ack_source_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_ready) |=> !ack_valid);

  p_stop_blocks_r13: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |-> !rx_ready);

  p_busy_nack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_index == '0 && wr_busy) |=> (ack_valid && !ack));

  p_wc_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wc_start) |-> $past(stop_det));

  p_wc_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wc_start |=> !wc_start);

  p_flags_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_flags) |-> wc_start);

  p_one_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(prot_flags) > $countones($past(prot_flags))) |->
      ($countones(prot_flags) == $countones($past(prot_flags)) + 1));

  p_page_on_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(page_sel) |-> $past(rx_valid && rx_ready && rx_index == '0));

endmodule

bind spd_cmd_decoder spd_cmd_decoder_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_index   (rx_index),
  .stop_det   (stop_det),
  .wr_busy    (wr_busy),
  .ack        (ack),
  .ack_valid  (ack_valid),
  .wc_start   (wc_start),
  .prot_flags (prot_flags),
  .page_sel   (page_sel)
);

// File: tb/spd_cmd_decoder_test.sv
`timescale 1ns/1ps
module spd_cmd_decoder_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_data = 8'h00;
  logic [1:0] rx_index = 2'd0;
  logic       stop_det = 1'b0;
  logic       wr_busy = 1'b0;
  logic [2:0] strap = 3'b011;
  logic       strap0_hv = 1'b0;
  logic       ack, ack_valid, wc_start, mem_active, mem_read, page_sel;
  logic [3:0] prot_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spd_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_index(rx_index), .stop_det(stop_det),
    .wr_busy(wr_busy), .strap(strap), .strap0_hv(strap0_hv), .ack(ack),
    .ack_valid(ack_valid), .wc_start(wc_start), .mem_active(mem_active),
    .mem_read(mem_read), .prot_flags(prot_flags), .page_sel(page_sel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // send one byte, then check the decision one cycle later
  task automatic send(input logic [7:0] b, input logic [1:0] idx, input bit exp, input string req);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_index = idx;
    @(negedge clk);
    rx_valid = 1'b0;
    check(ack_valid === 1'b1 && ack === exp, req, {ack_valid, ack}, {1'b1, exp});
  endtask

  task automatic stop(input bit exp_wc, input string req);
    @(negedge clk);
    stop_det = 1'b1;
    @(negedge clk);
    stop_det = 1'b0;
    check(wc_start === exp_wc, req, wc_start, exp_wc);
  endtask

  task automatic t_reset;
    check(page_sel === 1'b0 && prot_flags === 4'h0, "R9 reset state", {page_sel, prot_flags}, 0);
    check(ack_valid === 1'b0 && wc_start === 1'b0, "R9 no strobes", {ack_valid, wc_start}, 0);
  endtask

  task automatic t_mem_select;
    send(8'hA6, 2'd0, 1'b1, "R1 strap match");
    check(mem_active === 1'b1 && mem_read === 1'b0, "R1 write access open", {mem_active, mem_read}, 2);
    stop(1'b0, "R1 stop no commit");
    send(8'hA8, 2'd0, 1'b0, "R1 strap mismatch");
    send(8'hB6, 2'd0, 1'b0, "R10 foreign nibble");
  endtask

  task automatic t_set_nohv;
    strap0_hv = 1'b0;
    send(8'h62, 2'd0, 1'b0, "R3 set without hv");
    send(8'h66, 2'd0, 1'b0, "R3 clear without hv");
    stop(1'b0, "R3 no wc");
    check(prot_flags === 4'h0, "R3 flags unchanged", prot_flags, 0);
  endtask

  task automatic set_blk(input logic [7:0] sel, input logic [3:0] exp_flags, input string req);
    strap0_hv = 1'b1;
    send(sel, 2'd0, 1'b1, req);
    send(8'h00, 2'd1, 1'b1, req);
    send(8'h55, 2'd2, 1'b1, req);
    stop(1'b1, req);
    check(prot_flags === exp_flags, req, prot_flags, exp_flags);
    @(negedge clk);
    check(wc_start === 1'b0, "R2 single wc pulse", wc_start, 0);
    strap0_hv = 1'b0;
  endtask

  task automatic t_set_again;
    strap0_hv = 1'b1;
    send(8'h68, 2'd0, 1'b0, "R4 repeat select nack");
    send(8'h00, 2'd1, 1'b0, "R4 repeat addr nack");
    send(8'h00, 2'd2, 1'b0, "R4 repeat data nack");
    stop(1'b0, "R4 no wc");
    strap0_hv = 1'b0;
  endtask

  task automatic t_status;
    send(8'h69, 2'd0, 1'b0, "R7 blk1 protected");
    send(8'h00, 2'd1, 1'b0, "R7 following nack");
    send(8'h63, 2'd0, 1'b1, "R7 blk0 unprotected");
    strap0_hv = 1'b1;
    send(8'h61, 2'd0, 1'b1, "R7 blk3 with hv");
    strap0_hv = 1'b0;
    stop(1'b0, "R7 stop");
  endtask

  task automatic t_stop_early;
    strap0_hv = 1'b1;
    send(8'h6A, 2'd0, 1'b1, "R6 select");
    send(8'h00, 2'd1, 1'b1, "R6 addr");
    stop(1'b0, "R6 early stop no wc");
    check(prot_flags === 4'h2, "R6 flags unchanged", prot_flags, 2);
    strap0_hv = 1'b0;
  endtask

  task automatic t_mem_write;
    send(8'hA6, 2'd0, 1'b1, "R12 select");
    send(8'h85, 2'd1, 1'b1, "R12 address ack");
    send(8'h11, 2'd2, 1'b0, "R12 data to protected block1");
    send(8'h12, 2'd3, 1'b0, "R12 next data still protected");
    stop(1'b0, "R12 stop");
    send(8'hA6, 2'd0, 1'b1, "R12 select");
    send(8'h10, 2'd1, 1'b1, "R12 address low half");
    send(8'h22, 2'd2, 1'b1, "R12 data to block0");
    stop(1'b0, "R12 stop");
    send(8'hA7, 2'd0, 1'b1, "R12 read select");
    check(mem_read === 1'b1, "R12 read open", mem_read, 1);
    send(8'h00, 2'd1, 1'b0, "R12 read byte not acked");
    stop(1'b0, "R12 stop");
  endtask

  task automatic t_page;
    send(8'h6E, 2'd0, 1'b1, "R8 select page1");
    check(page_sel === 1'b1, "R8 page is 1", page_sel, 1);
    send(8'h6D, 2'd0, 1'b0, "R8 read page1 nack");
    send(8'hA6, 2'd0, 1'b1, "R8 select");
    send(8'h85, 2'd1, 1'b1, "R8 address");
    send(8'h33, 2'd2, 1'b1, "R12 page1 high half is block3");
    stop(1'b0, "R8 stop");
    send(8'h6C, 2'd0, 1'b1, "R8 select page0");
    check(page_sel === 1'b0, "R8 page is 0", page_sel, 0);
    send(8'h6D, 2'd0, 1'b1, "R8 read page0 ack");
    stop(1'b0, "R8 stop");
  endtask

  task automatic t_busy;
    wr_busy = 1'b1;
    send(8'hA6, 2'd0, 1'b0, "R11 mem select busy");
    send(8'h63, 2'd0, 1'b0, "R11 status busy");
    wr_busy = 1'b0;
    stop(1'b0, "R11 stop");
    send(8'hA6, 2'd0, 1'b1, "R11 after busy");
    stop(1'b0, "R11 stop");
  endtask

  task automatic t_unlisted;
    strap0_hv = 1'b1;
    send(8'h67, 2'd0, 1'b0, "R10 011 read");
    send(8'h6F, 2'd0, 1'b0, "R10 111 read");
    send(8'h64, 2'd0, 1'b0, "R10 010 write");
    send(8'h00, 2'd1, 1'b0, "R10 following nack");
    send(8'h00, 2'd2, 1'b0, "R10 following nack");
    stop(1'b0, "R10 no wc");
    strap0_hv = 1'b0;
  endtask

  task automatic t_stop_drop;
    @(negedge clk);
    stop_det = 1'b1; rx_valid = 1'b1; rx_data = 8'hA6; rx_index = 2'd0;
    #1;
    check(rx_ready === 1'b0, "R13 ready low at stop", rx_ready, 0);
    @(negedge clk);
    stop_det = 1'b0; rx_valid = 1'b0;
    check(ack_valid === 1'b0, "R13 dropped byte", ack_valid, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem_select();
    t_set_nohv();
    set_blk(8'h68, 4'h2, "R2 set blk1");
    t_set_again();
    t_status();
    t_stop_early();
    t_mem_write();
    t_page();
    t_busy();
    t_unlisted();
    set_blk(8'h60, 4'hA, "R2 set blk3");
    set_blk(8'h62, 4'hB, "R2 set blk0");
    set_blk(8'h6A, 4'hF, "R2 set blk2");
    strap0_hv = 1'b1;
    send(8'h66, 2'd0, 1'b1, "R5 clear select");
    send(8'h00, 2'd1, 1'b1, "R5 clear addr");
    send(8'h00, 2'd2, 1'b1, "R5 clear data");
    stop(1'b1, "R5 clear wc");
    check(prot_flags === 4'h0, "R5 all cleared", prot_flags, 0);
    strap0_hv = 1'b0;
    t_stop_drop();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule